// File: doc/BRIEF.md
# Paged Control-Block Queue Manager

This block sits between a host processor and an embedded sequencer and holds the command blocks the two exchange. A control-block store is split into fixed 32-byte pages. A page register picks one page, and that page appears in a 32-byte register window on both sides. The host fills a page while the sequencer is paused. It then hands the page number to the sequencer through an inbound pointer queue.

When the sequencer finishes a block, it returns the page number through an outbound pointer queue, and the host collects it from there. Each queue sits behind one register address, and a read of that address removes the entry it returns. A count register per queue lets either side see how many entries are waiting. Both sides use the same byte-wide register map. Read data is combinational: it is valid in the same cycle as the read strobe, and a popping read takes effect at the clock edge that ends that cycle.

Top module: `cb_queue_mgr`

## Requirements
- R1: After a synchronous active-low reset, both queue counts read 0, the page register reads 0 and both overflow outputs are low.
- R2: Address 90h holds the page register, writable and readable from either port. Only the low 4 bits are kept, and reads return them zero-extended. When both ports write it in the same cycle, the sequencer's value wins.
- R3: Addresses A0h-BFh read and write byte (address - A0h) of the page chosen by the page register. Both ports see the same bytes.
- R4: A host write to the window changes the store only while seq_paused is 1. With seq_paused at 0, it has no effect. Sequencer window writes always take effect, and the sequencer wins a same-cycle collision.
- R5: A host write to 9Bh pushes onto the inbound queue. A sequencer read of 9Bh returns the oldest entry and removes it, so entries leave in the order they arrived.
- R6: A sequencer write to 9Dh pushes onto the outbound queue. A host read of 9Dh returns the oldest entry and removes it, in arrival order.
- R7: From either port, 9Ch reads the inbound count and 9Eh reads the outbound count, each in the range 0 to 16.
- R8: A popping read of an empty queue returns 00h and leaves the count at 0.
- R9: A push onto a queue holding 16 entries is dropped. It sets that queue's overflow output (in_ovf or out_ovf), which then stays high until reset. A push and a pop in the same cycle on a full queue both take effect, and the overflow output is not set.
- R10: A push and a pop in the same cycle on a non-empty queue leave the count unchanged. The popped entry is the oldest one, and the new entry is queued last.
- R11: A host read or a sequencer write of 9Bh, and a sequencer read or a host write of 9Dh, change no queue. Those reads and reads of unmapped addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 8 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (pops on queue addresses) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational on h_addr |
| s_addr | input | 8 | Sequencer register address |
| s_wr | input | 1 | Sequencer write strobe |
| s_rd | input | 1 | Sequencer read strobe (pops on queue addresses) |
| s_wdata | input | 8 | Sequencer write data |
| s_rdata | output | 8 | Sequencer read data, combinational on s_addr |
| seq_paused | input | 1 | High while the sequencer is halted; gates host window writes |
| in_ovf | output | 1 | Sticky inbound overflow |
| out_ovf | output | 1 | Sticky outbound overflow |

## Verification
The bench fills a queue to exactly 16 entries and pushes once more. A design that wrapped its pointer would corrupt the oldest entry, and one that ignored the limit would report a count of 17. On the full queue the bench then pushes and pops in the same cycle; a design that checked fullness before applying the pop would drop the value and raise a false overflow. It also tries host window writes with the sequencer running, and reads the queues from the wrong side and while empty. A design missing either gate would alter the stored page or lose queued pointers, which shows up in the values the sequencer later reads back.

// File: rtl/cbq_pkg.sv
// Package cbq_pkg
// Shared register addresses and the per-port select bundle for the
// control-block queue manager. Assumes one byte-wide map for both ports.
package cbq_pkg;

    localparam logic [7:0] ADDR_PAGE   = 8'h90;
    localparam logic [7:0] ADDR_INQ    = 8'h9B;
    localparam logic [7:0] ADDR_INCNT  = 8'h9C;
    localparam logic [7:0] ADDR_OUTQ   = 8'h9D;
    localparam logic [7:0] ADDR_OUTCNT = 8'h9E;
    localparam logic [7:0] WIN_BASE    = 8'hA0;

    typedef struct packed {
        logic page;
        logic win;
        logic inq;
        logic incnt;
        logic outq;
        logic outcnt;
    } cbq_sel_t;

endpackage

// File: rtl/cbq_port_decode.sv
// Module cbq_port_decode
// Turns one port's register address into one-hot selects and a window
// byte offset. Assumes the window starts at WIN_BASE and fits below 100h.
module cbq_port_decode
    import cbq_pkg::*;
#(
    parameter int PAGE_BYTES = 32
) (
    input  logic [7:0]                      addr,
    output cbq_sel_t                        sel,
    output logic [$clog2(PAGE_BYTES)-1:0]   win_off
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [8:0] rel;

    // Offset of the address from the window base, one bit wider for range test
    always_comb rel = {1'b0, addr} - {1'b0, WIN_BASE};

    // Compare the address against every mapped register
    always_comb begin
        sel.page   = (addr == ADDR_PAGE);
        sel.inq    = (addr == ADDR_INQ);
        sel.incnt  = (addr == ADDR_INCNT);
        sel.outq   = (addr == ADDR_OUTQ);
        sel.outcnt = (addr == ADDR_OUTCNT);
        sel.win    = (addr >= WIN_BASE) && (rel < 9'(PAGE_BYTES));
        win_off    = rel[OFF_W-1:0];
    end

endmodule

// File: rtl/cbq_ptr_fifo.sv
// Module cbq_ptr_fifo
// Pointer queue with destructive read, occupancy count and a sticky
// overflow flag. Assumes DEPTH is a power of two and at least 2.
// A pop of an empty queue is ignored; a push at full is accepted only
// when a pop happens in the same cycle.
module cbq_ptr_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          empty, full, do_pop, do_push;

    // Qualify the requests against the current occupancy
    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == CW'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
    end

    // Store an accepted entry at the write pointer
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and track the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Latch a dropped push until reset
    always_ff @(posedge clk) begin
        if (!rst_n)               ovf_q <= 1'b0;
        else if (push && !do_push) ovf_q <= 1'b1;
    end

    // Present the oldest entry, or zero when nothing is queued
    always_comb begin
        head  = empty ? '0 : mem[rd_ptr];
        count = cnt_q;
        ovf   = ovf_q;
    end

endmodule

// File: rtl/cbq_page_ram.sv
// Module cbq_page_ram
// Control-block store of PAGES x PAGE_BYTES bytes with one write port
// and two combinational read ports (host side, sequencer side).
// Contents are not cleared by reset.
module cbq_page_ram #(
    parameter int PAGES      = 16,
    parameter int PAGE_BYTES = 32,
    parameter int DW         = 8
) (
    input  logic                                 clk,
    input  logic                                 we,
    input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]  waddr,
    input  logic [DW-1:0]                        wdata,
    input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]  raddr_a,
    output logic [DW-1:0]                        rdata_a,
    input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]  raddr_b,
    output logic [DW-1:0]                        rdata_b
);
    localparam int WORDS = PAGES * PAGE_BYTES;

    logic [DW-1:0] mem [WORDS];

    // Single write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Two independent asynchronous read ports
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end

endmodule

// File: rtl/cb_queue_mgr.sv
// Module cb_queue_mgr
// Top of the control-block queue manager. Decodes the host and sequencer
// register ports, owns the page register, arbitrates window writes
// (sequencer first, host only while paused) and steers both pointer queues.
// Assumes byte-wide pointers and a window of PAGE_BYTES at WIN_BASE.
module cb_queue_mgr
    import cbq_pkg::*;
#(
    parameter int PAGES      = 16,
    parameter int PAGE_BYTES = 32,
    parameter int DEPTH      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] h_addr,
    input  logic       h_wr,
    input  logic       h_rd,
    input  logic [7:0] h_wdata,
    output logic [7:0] h_rdata,
    input  logic [7:0] s_addr,
    input  logic       s_wr,
    input  logic       s_rd,
    input  logic [7:0] s_wdata,
    output logic [7:0] s_rdata,
    input  logic       seq_paused,
    output logic       in_ovf,
    output logic       out_ovf
);
    localparam int PG_W  = $clog2(PAGES);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int RA_W  = PG_W + OFF_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    cbq_sel_t           h_sel, s_sel;
    logic [OFF_W-1:0]   h_off, s_off;
    logic [PG_W-1:0]    page_q;
    logic               ram_we;
    logic [RA_W-1:0]    ram_waddr;
    logic [7:0]         ram_wdata;
    logic [7:0]         h_win_data, s_win_data;
    logic [7:0]         in_head, out_head;
    logic [CNT_W-1:0]   in_cnt, out_cnt;

    cbq_port_decode #(.PAGE_BYTES(PAGE_BYTES)) u_hdec (
        .addr(h_addr), .sel(h_sel), .win_off(h_off)
    );

    cbq_port_decode #(.PAGE_BYTES(PAGE_BYTES)) u_sdec (
        .addr(s_addr), .sel(s_sel), .win_off(s_off)
    );

    // Page register: sequencer write wins over a same-cycle host write
    always_ff @(posedge clk) begin
        if (!rst_n)                  page_q <= '0;
        else if (s_wr && s_sel.page) page_q <= s_wdata[PG_W-1:0];
        else if (h_wr && h_sel.page) page_q <= h_wdata[PG_W-1:0];
    end

    // Window write arbitration: sequencer always, host only while paused
    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = {page_q, s_off};
        ram_wdata = s_wdata;
        if (s_wr && s_sel.win) begin
            ram_we = 1'b1;
        end else if (h_wr && h_sel.win && seq_paused) begin
            ram_we    = 1'b1;
            ram_waddr = {page_q, h_off};
            ram_wdata = h_wdata;
        end
    end

    cbq_page_ram #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .DW(8)) u_ram (
        .clk    (clk),
        .we     (ram_we),
        .waddr  (ram_waddr),
        .wdata  (ram_wdata),
        .raddr_a({page_q, h_off}),
        .rdata_a(h_win_data),
        .raddr_b({page_q, s_off}),
        .rdata_b(s_win_data)
    );

    cbq_ptr_fifo #(.DW(8), .DEPTH(DEPTH)) u_inq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (h_wr && h_sel.inq),
        .push_data(h_wdata),
        .pop      (s_rd && s_sel.inq),
        .head     (in_head),
        .count    (in_cnt),
        .ovf      (in_ovf)
    );

    cbq_ptr_fifo #(.DW(8), .DEPTH(DEPTH)) u_outq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (s_wr && s_sel.outq),
        .push_data(s_wdata),
        .pop      (h_rd && h_sel.outq),
        .head     (out_head),
        .count    (out_cnt),
        .ovf      (out_ovf)
    );

    // Host read mux: outbound head is visible here, inbound is not
    always_comb begin
        h_rdata = 8'h00;
        if      (h_sel.page)   h_rdata = 8'(page_q);
        else if (h_sel.win)    h_rdata = h_win_data;
        else if (h_sel.incnt)  h_rdata = 8'(in_cnt);
        else if (h_sel.outq)   h_rdata = out_head;
        else if (h_sel.outcnt) h_rdata = 8'(out_cnt);
    end

    // Sequencer read mux: inbound head is visible here, outbound is not
    always_comb begin
        s_rdata = 8'h00;
        if      (s_sel.page)   s_rdata = 8'(page_q);
        else if (s_sel.win)    s_rdata = s_win_data;
        else if (s_sel.inq)    s_rdata = in_head;
        else if (s_sel.incnt)  s_rdata = 8'(in_cnt);
        else if (s_sel.outcnt) s_rdata = 8'(out_cnt);
    end

endmodule

// File: rtl/cbq_checker.sv
// Module cbq_checker
// Port-level properties of cb_queue_mgr, attached with bind below.
module cbq_checker
    import cbq_pkg::*;
#(
    parameter int PAGES = 16,
    parameter int DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] h_addr,
    input logic       h_wr,
    input logic [7:0] h_rdata,
    input logic [7:0] s_addr,
    input logic       s_wr,
    input logic       s_rd,
    input logic [7:0] s_rdata,
    input logic       seq_paused,
    input logic       in_ovf,
    input logic       out_ovf
);

    // R1
    reset_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!in_ovf && !out_ovf));

    // R9
    in_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ovf |=> in_ovf);

    // R9
    out_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |=> out_ovf);

    // R2
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_addr == ADDR_PAGE) |-> (h_rdata < 8'(PAGES)));

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_addr == ADDR_INCNT || s_addr == ADDR_OUTCNT) |-> (s_rdata <= 8'(DEPTH)));

    // R8
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd && s_addr == ADDR_INQ && h_addr == ADDR_INCNT && h_rdata == 8'h00)
        |-> (s_rdata == 8'h00));

    // R11
    host_inq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_addr == ADDR_INQ) |-> (h_rdata == 8'h00));

    // R11
    seq_outq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_addr == ADDR_OUTQ) |-> (s_rdata == 8'h00));

    // R4
    unpaused_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr[7:5] == 3'b101 && !seq_paused && !s_wr && s_addr == h_addr)
        ##1 (s_addr == $past(s_addr)) |-> (s_rdata == $past(s_rdata)));

endmodule

bind cb_queue_mgr cbq_checker #(.PAGES(PAGES), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_addr    (h_addr),
    .h_wr      (h_wr),
    .h_rdata   (h_rdata),
    .s_addr    (s_addr),
    .s_wr      (s_wr),
    .s_rd      (s_rd),
    .s_rdata   (s_rdata),
    .seq_paused(seq_paused),
    .in_ovf    (in_ovf),
    .out_ovf   (out_ovf)
);

// File: tb/cb_queue_mgr_test.sv
// Directed bench for cb_queue_mgr: one task per scenario, each checking
// its own results. Inputs change on the falling edge; combinational read
// data is sampled 1 ns later, before the next rising edge.
module cb_queue_mgr_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] h_addr = 8'h00, h_wdata = 8'h00, s_addr = 8'h00, s_wdata = 8'h00;
    logic       h_wr = 1'b0, h_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
    logic       seq_paused = 1'b1;
    logic [7:0] h_rdata, s_rdata;
    logic       in_ovf, out_ovf;

    int checks = 0;
    int errors = 0;

    cb_queue_mgr uut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .seq_paused(seq_paused), .in_ovf(in_ovf), .out_ovf(out_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(posedge clk); #1 h_wr = 1'b0;
    endtask

    task automatic sw(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); s_addr = a; s_wdata = d; s_wr = 1'b1;
        @(posedge clk); #1 s_wr = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); h_addr = a; h_rd = 1'b1; #1 d = h_rdata;
        @(posedge clk); #1 h_rd = 1'b0;
    endtask

    task automatic sr(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); s_addr = a; s_rd = 1'b1; #1 d = s_rdata;
        @(posedge clk); #1 s_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // R1: reset state observed at the ports
    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        hr(8'h9C, d); check("R1 inbound count", d, 8'h00);
        hr(8'h9E, d); check("R1 outbound count", d, 8'h00);
        sr(8'h90, d); check("R1 page", d, 8'h00);
        check("R1 in_ovf", {7'd0, in_ovf}, 8'h00);
        check("R1 out_ovf", {7'd0, out_ovf}, 8'h00);
    endtask

    // R2, R3: paging and the shared window
    task automatic t_paging();
        logic [7:0] d;
        seq_paused = 1'b1;
        hw(8'h90, 8'h03); hw(8'hA5, 8'h5A); hw(8'hBF, 8'h77);
        hw(8'h90, 8'h07); hw(8'hA5, 8'hC3);
        sr(8'hA5, d); check("R3 page 7 byte 5", d, 8'hC3);
        sw(8'h90, 8'h03);
        sr(8'hA5, d); check("R3 page 3 byte 5", d, 8'h5A);
        hr(8'hBF, d); check("R3 page 3 last byte", d, 8'h77);
        hw(8'h90, 8'hF5);
        sr(8'h90, d); check("R2 page low bits", d, 8'h05);
        // same-cycle page writes: sequencer wins
        @(negedge clk);
        h_addr = 8'h90; h_wdata = 8'h02; h_wr = 1'b1;
        s_addr = 8'h90; s_wdata = 8'h09; s_wr = 1'b1;
        @(posedge clk); #1 h_wr = 1'b0; s_wr = 1'b0;
        hr(8'h90, d); check("R2 collision", d, 8'h09);
    endtask

    // R4: host window writes gated by seq_paused
    task automatic t_pause_gate();
        logic [7:0] d;
        seq_paused = 1'b1;
        hw(8'h90, 8'h04); hw(8'hA0, 8'h22);
        seq_paused = 1'b0;
        hw(8'hA0, 8'h11);
        sr(8'hA0, d); check("R4 unpaused host write ignored", d, 8'h22);
        sw(8'hA1, 8'h33);
        hr(8'hA1, d); check("R4 sequencer write while running", d, 8'h33);
        seq_paused = 1'b1;
        @(negedge clk);
        h_addr = 8'hA2; h_wdata = 8'h44; h_wr = 1'b1;
        s_addr = 8'hA2; s_wdata = 8'h55; s_wr = 1'b1;
        @(posedge clk); #1 h_wr = 1'b0; s_wr = 1'b0;
        hr(8'hA2, d); check("R4 collision", d, 8'h55);
    endtask

    // R5, R6, R7: both queues in arrival order
    task automatic t_queues();
        logic [7:0] d;
        hw(8'h9B, 8'h0A); hw(8'h9B, 8'h0B); hw(8'h9B, 8'h0C);
        sr(8'h9C, d); check("R7 inbound count", d, 8'h03);
        sr(8'h9B, d); check("R5 first", d, 8'h0A);
        sr(8'h9B, d); check("R5 second", d, 8'h0B);
        hr(8'h9C, d); check("R7 inbound count after pops", d, 8'h01);
        sr(8'h9B, d); check("R5 third", d, 8'h0C);
        sw(8'h9D, 8'hE1); sw(8'h9D, 8'hE2);
        hr(8'h9E, d); check("R7 outbound count", d, 8'h02);
        hr(8'h9D, d); check("R6 first", d, 8'hE1);
        hr(8'h9D, d); check("R6 second", d, 8'hE2);
        sr(8'h9E, d); check("R7 outbound empty", d, 8'h00);
    endtask

    // R8: popping empty queues
    task automatic t_empty();
        logic [7:0] d;
        sr(8'h9B, d); check("R8 empty inbound read", d, 8'h00);
        hr(8'h9D, d); check("R8 empty outbound read", d, 8'h00);
        hr(8'h9C, d); check("R8 inbound count stays 0", d, 8'h00);
        hr(8'h9E, d); check("R8 outbound count stays 0", d, 8'h00);
    endtask

    // R10: push and pop together on the outbound queue
    task automatic t_simul();
        logic [7:0] d;
        sw(8'h9D, 8'h31); sw(8'h9D, 8'h32);
        @(negedge clk);
        s_addr = 8'h9D; s_wdata = 8'h33; s_wr = 1'b1;
        h_addr = 8'h9D; h_rd = 1'b1;
        #1 d = h_rdata;
        @(posedge clk); #1 s_wr = 1'b0; h_rd = 1'b0;
        check("R10 popped oldest", d, 8'h31);
        hr(8'h9E, d); check("R10 count unchanged", d, 8'h02);
        hr(8'h9D, d); check("R10 order next", d, 8'h32);
        hr(8'h9D, d); check("R10 order last", d, 8'h33);
    endtask

    // R9: full queue, dropped push, sticky flag, push+pop at full
    task automatic t_full();
        logic [7:0] d;
        for (int i = 0; i < 16; i++) hw(8'h9B, 8'(8'h40 + i));
        check("R9 no overflow at 16", {7'd0, in_ovf}, 8'h00);
        hw(8'h9B, 8'hEE);
        check("R9 overflow set", {7'd0, in_ovf}, 8'h01);
        hr(8'h9C, d); check("R9 count held at 16", d, 8'h10);
        @(negedge clk);
        h_addr = 8'h9B; h_wdata = 8'h77; h_wr = 1'b1;
        s_addr = 8'h9B; s_rd = 1'b1;
        #1 d = s_rdata;
        @(posedge clk); #1 h_wr = 1'b0; s_rd = 1'b0;
        check("R9 pop at full", d, 8'h40);
        hr(8'h9C, d); check("R9 count after push+pop", d, 8'h10);
        for (int i = 1; i < 16; i++) begin
            sr(8'h9B, d); check("R9 drain order", d, 8'(8'h40 + i));
        end
        sr(8'h9B, d); check("R9 late push kept last", d, 8'h77);
        check("R9 overflow sticky", {7'd0, in_ovf}, 8'h01);
        check("R9 outbound flag untouched", {7'd0, out_ovf}, 8'h00);
    endtask

    // R11: wrong-direction accesses and unmapped addresses
    task automatic t_wrong_dir();
        logic [7:0] d;
        hw(8'h9B, 8'h61); hw(8'h9B, 8'h62);
        hr(8'h9B, d); check("R11 host read inbound", d, 8'h00);
        sw(8'h9B, 8'h99);
        hr(8'h9C, d); check("R11 inbound count intact", d, 8'h02);
        sw(8'h9D, 8'h71);
        sr(8'h9D, d); check("R11 sequencer read outbound", d, 8'h00);
        hw(8'h9D, 8'h98);
        hr(8'h9E, d); check("R11 outbound count intact", d, 8'h01);
        hr(8'h40, d); check("R11 unmapped read", d, 8'h00);
        sr(8'h9B, d); check("R11 inbound first", d, 8'h61);
        sr(8'h9B, d); check("R11 inbound second", d, 8'h62);
        hr(8'h9D, d); check("R11 outbound entry", d, 8'h71);
    endtask

    initial begin
        t_reset();
        t_paging();
        t_pause_gate();
        t_queues();
        t_empty();
        t_simul();
        t_full();
        t_wrong_dir();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not complete, affects R1 through all tests");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule